// File: doc/BRIEF.md
# Serial CRC-8 Generator and Checker

This block computes an 8-bit cyclic redundancy check over a stream of single bits. It is sized for 64-bit device identity codes. Such a code carries an 8-bit family byte and a 48-bit serial number, least significant bit first, followed by an 8-bit check byte. The caller starts a code with a synchronous clear and then presents one bit per accepted transfer. The running remainder is always visible on `remainder`. After the 56 data bits it equals the check byte that belongs to the code.

To check a code, the caller feeds all 64 bits, including the received check byte. `residue_zero` goes high when exactly 64 bits have been accepted since the last clear and the remainder has come back to zero. Line timing, byte framing and the choice of how many bits to feed belong to the caller.

The bit input is a valid/ready stream. A bit transfers on a rising clock edge when `bit_valid` and `bit_ready` are both high. `bit_ready` is high on every cycle except one in which `clear` is asserted. In that cycle the offered bit is not taken, and the source must hold it and offer it again.

Top module: `crc8_serial`

## Requirements
- R1: After reset, `remainder` is 8'h00 and `residue_zero` is 0.
- R2: A cycle with `clear` high sets `remainder` to 8'h00 and the accepted-bit count to zero at the next edge. This holds even if `bit_valid` is high in the same cycle.
- R3: In a cycle with `bit_valid` low and `clear` low, `remainder` and `residue_zero` keep their values.
- R4: An accepted bit `d` updates the remainder `r` as follows. Let `f = d ^ r[0]`. The new remainder is `r >> 1`, XORed with 8'h8C when `f` is 1. This is the reflected form of x^8+x^5+x^4+1.
- R5: Start with a clear. Feed the bytes 02, 1C, B8, 01, 00, 00, 00 in that order, each least significant bit first. After these 56 bits, `remainder` reads 8'hA2.
- R6: After any 56 data bits, feed the 8 bits of the resulting remainder, least significant bit first. `remainder` then returns to 8'h00 and `residue_zero` is 1.
- R7: `residue_zero` is 1 only when the count of bits accepted since the last clear is exactly 64 and `remainder` is zero. It is 0 for a code with any bit flipped and 0 once a 65th bit is accepted. The count saturates above 64.
- R8: `bit_ready` is 1 whenever `clear` is 0 and 0 whenever `clear` is 1. A bit is consumed only on an edge where `bit_valid` and `bit_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of remainder and bit count |
| bit_valid | input | 1 | A data bit is offered on `bit_in` |
| bit_ready | output | 1 | The block can take the offered bit this cycle |
| bit_in | input | 1 | Serial data bit, least significant first |
| remainder | output | 8 | Current CRC remainder |
| residue_zero | output | 1 | Exactly 64 bits accepted and remainder is zero |

## Verification
`bit_ready` is combinational, so the bench reads it in the same cycle the stimulus is driven, before the clock edge. `remainder` and `residue_zero` reflect a transfer or a clear one edge later. The bench therefore drives each stimulus at a falling edge and updates its behavioural model at the following rising edge. It compares both outputs at the falling edge after that. Hold cycles, the clear-with-valid collision and the 65th bit are each compared at that same one-cycle point.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int unsigned CRC_W     = 8;
  localparam logic [7:0]  POLY_REFL = 8'h8C;
  localparam int unsigned CODE_BITS = 64;
endpackage

// File: rtl/crc8_step.sv
// One-bit advance of a reflected (right-shifting) CRC register.
module crc8_step #(
  parameter int unsigned      W    = 8,
  parameter logic [W-1:0]     POLY = 8'h8C
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb = din ^ cur[0];

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == W - 1) begin : g_top
      assign nxt[i] = POLY[i] & fb;
    end else begin : g_mid
      assign nxt[i] = cur[i+1] ^ (POLY[i] & fb);
    end
  end
endmodule

// File: rtl/crc8_bitcount.sv
// Counts accepted bits since clear, saturating one past the code length.
module crc8_bitcount #(
  parameter int unsigned CODE_BITS = 64,
  localparam int unsigned CNT_W    = $clog2(CODE_BITS + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  output logic at_full
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CODE_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CODE_BITS + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (clear)                    cnt <= '0;
    else if (take && cnt != CNT_OVER)  cnt <= cnt + 1'b1;
  end

  assign at_full = (cnt == CNT_FULL);

  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER);
endmodule

// File: rtl/crc8_serial.sv
module crc8_serial
  import crc8_pkg::*;
#(
  parameter int unsigned      W         = CRC_W,
  parameter logic [W-1:0]     POLY      = POLY_REFL,
  parameter int unsigned      CODE_LEN  = CODE_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         bit_valid,
  output logic         bit_ready,
  input  logic         bit_in,
  output logic [W-1:0] remainder,
  output logic         residue_zero
);
  logic         take;
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_nxt;
  logic         full;

  assign bit_ready = ~clear;
  assign take      = bit_valid & bit_ready;

  crc8_step #(.W(W), .POLY(POLY)) u_step (
    .cur (crc_q),
    .din (bit_in),
    .nxt (crc_nxt)
  );

  crc8_bitcount #(.CODE_BITS(CODE_LEN)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .take    (take),
    .at_full (full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= '0;
    else if (clear) crc_q <= '0;
    else if (take)  crc_q <= crc_nxt;
  end

  assign remainder    = crc_q;
  assign residue_zero = full & (crc_q == '0);

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (remainder == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !clear) |=> ($stable(remainder) && $stable(residue_zero)));

  // R4
  msb_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !clear) |=> (remainder[W-1] == ($past(bit_in) ^ $past(remainder[0]))));
endmodule

// File: tb/crc8_serial_bench.sv
module crc8_serial_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       bit_ready;
  logic [7:0] remainder;
  logic       residue_zero;

  int errors = 0;
  int checks = 0;
  int m_crc  = 0;
  int m_cnt  = 0;
  int unsigned seed = 32'h1BADF00D;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc8_serial u_crc8_serial (
    .clk(clk), .rst_n(rst_n), .clear(clear), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .bit_in(bit_in), .remainder(remainder),
    .residue_zero(residue_zero)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nxt_rand();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return int'(seed);
  endfunction

  // Drive one cycle at the falling edge; model updates on the rising edge;
  // outputs compared at the following falling edge.
  task automatic step(input bit clr, input bit v, input bit b, input string req);
    clear = clr; bit_valid = v; bit_in = b;
    #1;
    check("R8 bit_ready", int'(bit_ready), clr ? 0 : 1);
    @(posedge clk);
    if (clr) begin
      m_crc = 0; m_cnt = 0;
    end else if (v) begin
      if (((m_crc & 1) ^ int'(b)) != 0) m_crc = (m_crc >> 1) ^ 'h8C;
      else                               m_crc = m_crc >> 1;
      if (m_cnt < 65) m_cnt++;
    end
    @(negedge clk);
    check({req, " remainder"}, int'(remainder), m_crc);
    check({req, " residue_zero"}, int'(residue_zero),
          (m_cnt == 64 && m_crc == 0) ? 1 : 0);
  endtask

  task automatic feed56(input logic [55:0] data, input bit gaps);
    for (int i = 0; i < 56; i++) begin
      if (gaps && (nxt_rand() & 3) == 0) step(1'b0, 1'b0, 1'b1, "R3 gap");
      step(1'b0, 1'b1, data[i], "R4 data");
    end
  endtask

  task automatic feed_crc(input logic [7:0] c);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, c[i], "R6 crc");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0]  c;
    logic [55:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 remainder", int'(remainder), 0);
    check("R1 residue_zero", int'(residue_zero), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(remainder), 0);

    // R5 known code
    step(1'b1, 1'b0, 1'b0, "R2 clear");
    feed56(56'h00000001B81C02, 1'b0);
    check("R5 known check byte", int'(remainder), 'hA2);
    feed_crc(8'hA2);
    check("R6 residue flag", int'(residue_zero), 1);

    // R3 idle holds
    repeat (4) step(1'b0, 1'b0, 1'b1, "R3 idle");
    check("R3 flag held", int'(residue_zero), 1);

    // R7 65th bit drops flag, more bits keep it low
    step(1'b0, 1'b1, 1'b0, "R7 extra bit");
    check("R7 flag after 65", int'(residue_zero), 0);
    repeat (3) step(1'b0, 1'b1, 1'b0, "R7 beyond");

    // R2 clear beats valid
    step(1'b1, 1'b1, 1'b1, "R2 clear with valid");
    check("R2 cleared", int'(remainder), 0);

    // R6/R7 random codes with gaps, plus corrupted variant
    for (int k = 0; k < 12; k++) begin
      d = {24'(nxt_rand()), 32'(nxt_rand())};
      step(1'b1, 1'b0, 1'b0, "R2 clear");
      feed56(d, 1'b1);
      c = 8'(m_crc);
      feed_crc(c);
      check("R6 random good code", int'(residue_zero), 1);
      step(1'b1, 1'b0, 1'b0, "R2 clear");
      d[k*4] = ~d[k*4];
      feed56(d, 1'b0);
      feed_crc(c);
      check("R7 corrupted code", int'(residue_zero), 0);
    end

    // R7 flipped check byte bit
    step(1'b1, 1'b0, 1'b0, "R2 clear");
    feed56(56'h00000001B81C02, 1'b0);
    feed_crc(8'hA3);
    check("R7 bad check byte", int'(residue_zero), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule